// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Unit

This block keeps the 8-bit status byte of a small serial flash memory and decides whether each modifying operation may proceed. A command decoder elsewhere in the chip reports write-enable and write-disable commands to it. It also presents the operation it wants to start, with the target address and, for a status write, the new status data. It signals the start and the end of each self-timed cycle. The unit returns the live status byte for status reads, and four combinational verdicts: page program, sector erase, bulk erase and status write.

The block-protect field and the status-write-disable bit stand for non-volatile cells. They are modelled as registers that reset to a delivery value. They change only when an accepted status-write cycle completes. The write-enable latch and the busy bit are volatile. The active-low write-protect pin, together with the disable bit, locks the status byte against writes. The lock forms in whichever order the two conditions arise, and it is released only by raising the pin.

Top module: `flash_guard`

## Requirements
- R1: After reset the status byte reads 00h and every verdict output is 0.
- R2: The status byte is laid out with bit 7 as the status-write-disable bit, bits 6 to 4 always 0, bit 3 as the upper block-protect bit, bit 2 as the lower block-protect bit, bit 1 as the write-enable latch and bit 0 as the busy bit.
- R3: A write-enable pulse sets the latch in the next cycle and a write-disable pulse clears it; when both arrive together the latch clears; both are ignored while busy.
- R4: Every verdict output is 0 while the latch is 0 or the busy bit is 1.
- R5: With req_op encoded as 1 program, 2 sector erase, 3 bulk erase, 4 status write and 0 none, a start pulse whose operation is allowed sets the busy bit in the next cycle; a start pulse for a denied operation changes nothing.
- R6: A done pulse while busy clears the busy bit and the latch in the next cycle; a done pulse while idle has no effect.
- R7: When an accepted status write completes, only bits 7, 3 and 2 take the written data; bits 6 to 4 stay 0 and bits 1 and 0 do not follow the data.
- R8: Program and sector erase are allowed at any address unless both block-protect bits are 1, which protects every sector.
- R9: Bulk erase is allowed only when both block-protect bits are 0.
- R10: A status write is denied while the disable bit is 1 and the write-protect pin is low, whichever of the two became true first; raising the pin allows it again.
- R11: A start pulse in the same cycle as a write-disable pulse is judged on the latch value before that edge, so the cycle starts and the latch still ends cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wren | input | 1 | Write-enable command pulse |
| cmd_wrdi | input | 1 | Write-disable command pulse |
| wp_n | input | 1 | Write-protect pin, active low |
| req_op | input | 3 | Requested operation: 0 none, 1 program, 2 sector erase, 3 bulk erase, 4 status write |
| req_addr | input | ADDR_W | Target byte address; its top bits select the sector |
| req_wdata | input | 8 | New status data for a status write |
| cyc_start | input | 1 | Start pulse for the requested operation |
| cyc_done | input | 1 | End of the running self-timed cycle |
| status | output | 8 | Live status byte |
| allow_prog | output | 1 | Page program permitted at req_addr |
| allow_serase | output | 1 | Sector erase permitted at req_addr |
| allow_berase | output | 1 | Bulk erase permitted |
| allow_wstat | output | 1 | Status write permitted |

## Verification
Two of the block's functions can fall in the same cycle. A cycle can start while a write-disable command arrives, and a status write can complete while the write-protect pin is already low. The bench drives the start and disable pulses at the same falling edge. It then expects the busy bit set and the latch clear on the next sample. In the second case it commits the disable bit with the pin held low. The status-write verdict must read 0 as soon as the commit is visible and must return to 1 only after the pin rises. Around these cases the bench sweeps every block-protect value, disable bit and pin level, at addresses in both sectors, and compares each verdict with values it computes itself.

// File: rtl/flash_guard_pkg.sv
// Package: shared types for the flash status and protection unit.
// Assumes a 3-bit operation code supplied by the command decoder.
package flash_guard_pkg;

    // Operation requested by the command decoder.
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_SERASE = 3'd2,
        OP_BERASE = 3'd3,
        OP_WSTAT  = 3'd4
    } fg_op_e;

    // Status-byte bit positions.
    localparam int unsigned SB_WIP  = 0;
    localparam int unsigned SB_WEL  = 1;
    localparam int unsigned SB_BP0  = 2;
    localparam int unsigned SB_BP1  = 3;
    localparam int unsigned SB_SRWD = 7;

    // Non-volatile fields held in one small struct.
    typedef struct packed {
        logic       srwd;
        logic [1:0] bp;
    } fg_nv_t;

endpackage

// File: rtl/fg_cycle_ctrl.sv
// Module: fg_cycle_ctrl
// Tracks the self-timed cycle. An accepted start sets the busy bit and
// latches the operation and the status-write data. A done pulse while busy
// ends the cycle and raises a one-cycle end event. A commit pulse follows
// when the finished cycle was a status write.
// Assumes the start pulse is only honoured when start_ok is high.
module fg_cycle_ctrl
    import flash_guard_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cyc_start,
    input  logic   cyc_done,
    input  logic   start_ok,
    input  fg_op_e op,
    input  fg_nv_t wdata_nv,
    output logic   wip,
    output logic   end_evt,
    output logic   commit,
    output fg_nv_t pend_nv
);

    fg_op_e cur_op_q;
    logic   take;

    assign take    = cyc_start && start_ok;
    assign end_evt = cyc_done && wip;
    assign commit  = end_evt && (cur_op_q == OP_WSTAT);

    // Busy bit: set on accepted start, cleared on done while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)       wip <= 1'b0;
        else if (end_evt) wip <= 1'b0;
        else if (take)    wip <= 1'b1;
    end

    // Latch the running operation and its status payload at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op_q <= OP_NONE;
            pend_nv  <= '0;
        end else if (take) begin
            cur_op_q <= op;
            pend_nv  <= wdata_nv;
        end
    end

    a_r5_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> wip);
    a_r6_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && wip) |=> !wip);
    a_r6_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wip && !take) |=> !wip);

endmodule

// File: rtl/fg_status_regs.sv
// Module: fg_status_regs
// Holds the write-enable latch and the non-volatile fields (disable bit and
// block-protect bits). The non-volatile fields reset to the delivery value
// and change only on a commit from the cycle controller. The latch clears at
// every cycle end, ahead of write-disable and write-enable.
// Assumes enable/disable commands are ignored while a cycle runs.
module fg_status_regs
    import flash_guard_pkg::*;
#(
    parameter logic [7:0] DELIVERY = 8'h00
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_wren,
    input  logic   cmd_wrdi,
    input  logic   wip,
    input  logic   end_evt,
    input  logic   commit,
    input  fg_nv_t pend_nv,
    output logic   wel,
    output fg_nv_t nv
);

    localparam fg_nv_t NV_INIT = '{srwd: DELIVERY[SB_SRWD],
                                   bp:   DELIVERY[SB_BP1:SB_BP0]};

    // Write-enable latch: end of cycle, then disable, then enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        wel <= 1'b0;
        else if (end_evt)  wel <= 1'b0;
        else if (!wip) begin
            if (cmd_wrdi)      wel <= 1'b0;
            else if (cmd_wren) wel <= 1'b1;
        end
    end

    // Non-volatile fields: load on committed status write only.
    always_ff @(posedge clk) begin
        if (!rst_n)      nv <= NV_INIT;
        else if (commit) nv <= pend_nv;
    end

    a_r7_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(nv));
    a_r6_wel_end: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> !wel);
    a_r3_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrdi && !wip) |=> !wel);
    a_r3_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !cmd_wrdi && !wip) |=> wel);
    a_r3_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !wel) |=> !wel);

endmodule

// File: rtl/fg_protect_eval.sv
// Module: fg_protect_eval
// Combinational verdicts. Sector protection is computed per sector from the
// block-protect field (code 3 protects every sector; codes 1 and 2 protect
// none for program and erase but still forbid bulk erase). Hardware lock =
// disable bit with pin low. All verdicts need the latch set and no cycle
// running. Also picks the verdict matching the requested operation.
// Assumes the sector is the top SECT_W bits of the address.
module fg_protect_eval
    import flash_guard_pkg::*;
#(
    parameter int unsigned SECT_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel,
    input  logic              wip,
    input  logic              wp_n,
    input  fg_nv_t            nv,
    input  logic [SECT_W-1:0] sect,
    input  fg_op_e            op,
    output logic              allow_prog,
    output logic              allow_serase,
    output logic              allow_berase,
    output logic              allow_wstat,
    output logic              start_ok
);

    localparam int unsigned NSECT = 1 << SECT_W;

    logic [NSECT-1:0] prot_vec;
    logic             gate;
    logic             hw_lock;

    // One protection flag per sector.
    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        assign prot_vec[s] = (nv.bp == 2'b11);
    end

    assign gate    = wel && !wip;
    assign hw_lock = nv.srwd && !wp_n;

    // Verdicts per operation.
    always_comb begin
        allow_prog   = gate && !prot_vec[sect];
        allow_serase = gate && !prot_vec[sect];
        allow_berase = gate && (nv.bp == 2'b00);
        allow_wstat  = gate && !hw_lock;
    end

    // Select the verdict for the operation being started.
    always_comb begin
        unique case (op)
            OP_PROG:   start_ok = allow_prog;
            OP_SERASE: start_ok = allow_serase;
            OP_BERASE: start_ok = allow_berase;
            OP_WSTAT:  start_ok = allow_wstat;
            default:   start_ok = 1'b0;
        endcase
    end

    a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!wel || wip) |-> !(allow_prog || allow_serase || allow_berase || allow_wstat));
    a_r8_all_protected: assert property (@(posedge clk) disable iff (!rst_n)
        (nv.bp == 2'b11) |-> (!allow_prog && !allow_serase));
    a_r9_bulk_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (nv.bp != 2'b00) |-> !allow_berase);
    a_r10_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (nv.srwd && !wp_n) |-> !allow_wstat);

endmodule

// File: rtl/flash_guard.sv
// Module: flash_guard (top)
// Status register and write-protection unit for a small serial flash.
// Ties together the cycle controller, the status registers and the
// protection evaluator, and assembles the status byte.
// Assumes single-cycle command, start and done pulses from the decoder.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned SECT_W   = 1,
    parameter logic [7:0]  DELIVERY = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              wp_n,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    input  logic              cyc_start,
    input  logic              cyc_done,
    output logic [7:0]        status,
    output logic              allow_prog,
    output logic              allow_serase,
    output logic              allow_berase,
    output logic              allow_wstat
);

    localparam int unsigned LOW_W = ADDR_W - SECT_W;

    fg_op_e            op;
    fg_nv_t            nv;
    fg_nv_t            wdata_nv;
    fg_nv_t            pend_nv;
    logic              wel;
    logic              wip;
    logic              end_evt;
    logic              commit;
    logic              start_ok;
    logic [SECT_W-1:0] sect;
    logic              unused_bits;

    assign op          = fg_op_e'(req_op);
    assign sect        = req_addr[ADDR_W-1 -: SECT_W];
    assign wdata_nv    = '{srwd: req_wdata[SB_SRWD], bp: req_wdata[SB_BP1:SB_BP0]};
    assign unused_bits = ^{req_addr[LOW_W-1:0], req_wdata[6:4], req_wdata[1:0]};

    fg_cycle_ctrl u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_done  (cyc_done),
        .start_ok  (start_ok),
        .op        (op),
        .wdata_nv  (wdata_nv),
        .wip       (wip),
        .end_evt   (end_evt),
        .commit    (commit),
        .pend_nv   (pend_nv)
    );

    fg_status_regs #(.DELIVERY(DELIVERY)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wren (cmd_wren),
        .cmd_wrdi (cmd_wrdi),
        .wip      (wip),
        .end_evt  (end_evt),
        .commit   (commit),
        .pend_nv  (pend_nv),
        .wel      (wel),
        .nv       (nv)
    );

    fg_protect_eval #(.SECT_W(SECT_W)) u_prot (
        .clk          (clk),
        .rst_n        (rst_n),
        .wel          (wel),
        .wip          (wip),
        .wp_n         (wp_n),
        .nv           (nv),
        .sect         (sect),
        .op           (op),
        .allow_prog   (allow_prog),
        .allow_serase (allow_serase),
        .allow_berase (allow_berase),
        .allow_wstat  (allow_wstat),
        .start_ok     (start_ok)
    );

    // Assemble the status byte; bits 6..4 are fixed at zero.
    always_comb begin
        status          = 8'h00;
        status[SB_SRWD] = nv.srwd;
        status[SB_BP1]  = nv.bp[1];
        status[SB_BP0]  = nv.bp[0];
        status[SB_WEL]  = wel;
        status[SB_WIP]  = wip;
    end

    a_r2_zero_field: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:4] == 3'b000);
    a_r11_start_with_wrdi: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && start_ok && cmd_wrdi) |=> (wip && !wel));

endmodule

// File: tb/sim_flash_guard.sv
// Bench for flash_guard: sweeps every protect code, disable bit, pin level
// and sector, plus ordering and same-cycle cases.
module sim_flash_guard;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wren = 1'b0;
    logic        cmd_wrdi = 1'b0;
    logic        wp_n = 1'b1;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] req_addr = 16'h0000;
    logic [7:0]  req_wdata = 8'h00;
    logic        cyc_start = 1'b0;
    logic        cyc_done = 1'b0;
    logic [7:0]  status;
    logic        allow_prog, allow_serase, allow_berase, allow_wstat;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    flash_guard u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .wp_n(wp_n), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .cyc_start(cyc_start), .cyc_done(cyc_done), .status(status),
        .allow_prog(allow_prog), .allow_serase(allow_serase),
        .allow_berase(allow_berase), .allow_wstat(allow_wstat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    endtask

    function automatic logic [7:0] verdicts();
        return {4'b0, allow_prog, allow_serase, allow_berase, allow_wstat};
    endfunction

    task automatic pulse_wren();
        cmd_wren = 1'b1; tick(); cmd_wren = 1'b0;
    endtask

    task automatic pulse_wrdi();
        cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0;
    endtask

    // Enable, start a status write with data d, then finish it.
    task automatic write_status(input logic [7:0] d);
        pulse_wren();
        req_op = 3'd4; req_wdata = d; cyc_start = 1'b1; tick(); cyc_start = 1'b0;
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        req_op = 3'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) tick();
        #1;
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset verdicts", verdicts(), 8'h00);
        rst_n = 1'b1;
        tick();

        // R3: enable, disable, both together
        pulse_wren();
        chk("R3 wren sets latch", status, 8'h02);
        pulse_wrdi();
        chk("R3 wrdi clears latch", status, 8'h00);
        pulse_wren();
        cmd_wren = 1'b1; cmd_wrdi = 1'b1; tick(); cmd_wren = 1'b0; cmd_wrdi = 1'b0;
        chk("R3 both -> clear", status, 8'h00);

        // R5: start without latch is ignored
        req_op = 3'd1; cyc_start = 1'b1; tick(); cyc_start = 1'b0; req_op = 3'd0;
        chk("R5 denied start", status, 8'h00);

        // R6: done while idle has no effect on latch
        pulse_wren();
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk("R6 idle done", status, 8'h02);

        // R5/R4/R3: program cycle, busy gating, wren ignored while busy
        req_op = 3'd1; req_addr = 16'h0040; cyc_start = 1'b1; tick(); cyc_start = 1'b0;
        chk("R5 start sets busy", status, 8'h03);
        #1;
        chk("R4 busy blocks verdicts", verdicts(), 8'h00);
        pulse_wrdi();
        chk("R3 wrdi ignored busy", status, 8'h03);
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk("R6 done clears busy+latch", status, 8'h00);
        pulse_wren();
        cmd_wren = 1'b1; tick(); cmd_wren = 1'b0;
        req_op = 3'd3; cyc_start = 1'b1; tick(); cyc_start = 1'b0;
        chk("R5 bulk start", status, 8'h03);
        pulse_wren();
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk("R3 wren ignored busy", status, 8'h00);

        // R11: start and write-disable in the same cycle
        pulse_wren();
        req_op = 3'd2; req_addr = 16'h8000; cyc_start = 1'b1; cmd_wrdi = 1'b1; tick();
        cyc_start = 1'b0; cmd_wrdi = 1'b0;
        chk("R11 start with wrdi", status, 8'h01);
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk("R11 cycle end", status, 8'h00);

        // R7: only bits 7,3,2 take data
        wp_n = 1'b1;
        write_status(8'hFF);
        chk("R7 all-ones data", status, 8'h8C);
        write_status(8'h73);
        chk("R7 masked data", status, 8'h00);

        // R8/R9/R10/R2/R4: full sweep
        for (int bp = 0; bp < 4; bp++) begin
            for (int sr = 0; sr < 2; sr++) begin
                for (int wp = 0; wp < 2; wp++) begin
                    logic [7:0] sb;
                    sb = {sr[0], 3'b000, bp[1:0], 2'b00};
                    wp_n = 1'b1;
                    write_status(sb);
                    chk("R2 status layout", status, sb);
                    wp_n = wp[0];
                    pulse_wren();
                    chk("R2 latch bit", status, sb | 8'h02);
                    for (int sc = 0; sc < 2; sc++) begin
                        logic [7:0] exp;
                        req_addr = (sc == 0) ? 16'h1234 : 16'hC0DE;
                        #1;
                        exp = {4'b0, bp != 3, bp != 3, bp == 0, !(sr == 1 && wp == 0)};
                        chk("R8 R9 R10 verdicts", verdicts(), exp);
                    end
                    pulse_wrdi();
                    #1;
                    chk("R4 latch off", verdicts(), 8'h00);
                end
            end
        end

        // R10: pin low first, then commit disable bit
        wp_n = 1'b1;
        write_status(8'h00);
        wp_n = 1'b0;
        write_status(8'h80);
        chk("R10 commit with pin low", status, 8'h80);
        pulse_wren();
        #1;
        chk("R10 locked after commit", {7'b0, allow_wstat}, 8'h00);
        req_op = 3'd4; req_wdata = 8'h00; cyc_start = 1'b1; tick(); cyc_start = 1'b0;
        req_op = 3'd0;
        chk("R10 locked start ignored", status, 8'h82);
        wp_n = 1'b1;
        #1;
        chk("R10 pin high unlocks", {7'b0, allow_wstat}, 8'h01);
        pulse_wrdi();
        write_status(8'h00);
        chk("R7 cleared", status, 8'h00);

        summary();
    end

endmodule